// File: doc/BRIEF.md
# Delay-Line Edge Timestamp Encoder

This block turns a captured snapshot of a delay-locked line into a binary arrival time. The line has sixteen delay stages that together span one reference clock period. The output of each stage is sampled at eight evenly staggered instants, so the snapshot holds 128 bits. Each bit shows the level of the reference clock at one fine position in the period. The block finds the single place where the clock's rising edge has just left a stage. That place is given as a stage number and a sub-sample number. The block joins this fine position to a coarse cycle count, which comes from a counter running on the reference clock.

The captured array is presented together with a one-cycle `hit_valid` strobe. The coarse count is sampled on the same edge, so a hit that falls at the very start of a period keeps the count that belonged to it, even when the counter rolls over in the next cycle. A snapshot is rejected when it shows no rising transition, or more than one (bubbles). A rejected snapshot raises an error flag, and its fine field reads zero. The result stays on the outputs until the next hit.

Top module: `dll_edge_timestamp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ts_valid`, `ts_err` and `ts_value` are all zero.
- R2: `ts_valid` is high for exactly the cycle after each cycle in which `hit_valid` is high, and low in every other cycle.
- R3: Bit `stage*8+sub` of `hit_samples` is the level seen at stage `stage` (0..15) and sub-sample `sub` (0..7). A position p is a rising transition when bit p is 1 and the bit before it is 0. When the snapshot has exactly one such position, `ts_value[6:0]` equals p, with `ts_value[6:3]` the stage and `ts_value[2:0]` the sub-sample, and `ts_err` is 0.
- R4: The positions wrap around: the bit before position 0 is bit 127. A snapshot whose only rising transition is at stage 0 / sub-sample 0 therefore encodes fine value 0 without error.
- R5: A snapshot with no rising transition (all zeros or all ones) sets `ts_err` to 1 and forces `ts_value[6:0]` to 0.
- R6: A snapshot with two or more rising transitions sets `ts_err` to 1 and forces `ts_value[6:0]` to 0.
- R7: `ts_value[18:7]` equals the value of `coarse_count` in the cycle in which `hit_valid` was high. A later change of the counter, a rollover included, does not alter it.
- R8: While `hit_valid` is low, `ts_value` and `ts_err` keep their values, whatever `hit_samples` and `coarse_count` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_valid | input | 1 | One-cycle strobe: snapshot and count are valid |
| hit_samples | input | 128 | Captured line state, bit index stage*8+sub |
| coarse_count | input | 12 | Cycle counter running on the reference clock |
| ts_valid | output | 1 | Result strobe, one cycle after the hit |
| ts_value | output | 19 | {coarse, stage[3:0], sub[2:0]} |
| ts_err | output | 1 | Snapshot had no rising transition or more than one |

## Verification
Each result is due exactly one clock edge after its strobe. The snapshot, the count and `hit_valid` are all captured on the edge that sees the strobe, and the new timestamp, error flag and `ts_valid` become visible just after that edge. The bench drives its stimulus on falling edges and reads the outputs on the next falling edge, half a cycle after the capturing edge. For the hold checks it changes the inputs over several strobe-free cycles and reads the outputs again on falling edges. For the rollover case it moves the counter straight after the capturing edge, so a design that captured one cycle late would read the wrong count.

// File: rtl/dll_ts_pkg.sv
package dll_ts_pkg;
    localparam int DEF_STAGES  = 16;
    localparam int DEF_SUBS    = 8;
    localparam int DEF_COARSE_W = 12;

    typedef enum logic [1:0] {
        EDGE_OK    = 2'd0,
        EDGE_NONE  = 2'd1,
        EDGE_MULTI = 2'd2
    } edge_status_e;
endpackage

// File: rtl/dll_rise_finder.sv
module dll_rise_finder #(
    parameter int TAPS = 128
) (
    input  logic [TAPS-1:0] snap_i,
    output logic [TAPS-1:0] rise_o
);
    // A rising transition sits where a one follows a zero; position 0
    // looks back to the last tap, closing the period.
    genvar k;
    generate
        for (k = 0; k < TAPS; k++) begin : g_tap
            if (k == 0) begin : g_wrap
                assign rise_o[k] = snap_i[0] & ~snap_i[TAPS-1];
            end else begin : g_mid
                assign rise_o[k] = snap_i[k] & ~snap_i[k-1];
            end
        end
    endgenerate
endmodule

// File: rtl/dll_rise_encoder.sv
module dll_rise_encoder
    import dll_ts_pkg::*;
#(
    parameter int TAPS   = 128,
    localparam int FINE_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   rise_i,
    output logic [FINE_W-1:0] index_o,
    output edge_status_e      status_o
);
    logic [FINE_W-1:0] or_index;
    logic              any_rise;
    logic              many_rise;

    always_comb begin
        or_index = '0;
        for (int k = 0; k < TAPS; k++) begin
            if (rise_i[k]) or_index = or_index | FINE_W'(k);
        end
    end

    assign any_rise  = |rise_i;
    assign many_rise = |(rise_i & (rise_i - TAPS'(1)));

    always_comb begin
        if (!any_rise)       status_o = EDGE_NONE;
        else if (many_rise)  status_o = EDGE_MULTI;
        else                 status_o = EDGE_OK;
    end

    assign index_o = (status_o == EDGE_OK) ? or_index : '0;

    // R3
    always_comb begin
        if (status_o == EDGE_OK) begin
            index_hits_rise_chk: assert (rise_i[index_o]);
        end
    end
endmodule

// File: rtl/dll_edge_timestamp.sv
module dll_edge_timestamp
    import dll_ts_pkg::*;
#(
    parameter int STAGES   = DEF_STAGES,
    parameter int SUBS     = DEF_SUBS,
    parameter int COARSE_W = DEF_COARSE_W,
    localparam int TAPS    = STAGES * SUBS,
    localparam int FINE_W  = $clog2(TAPS),
    localparam int TS_W    = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit_valid,
    input  logic [TAPS-1:0]     hit_samples,
    input  logic [COARSE_W-1:0] coarse_count,
    output logic                ts_valid,
    output logic [TS_W-1:0]     ts_value,
    output logic                ts_err
);
    logic [TAPS-1:0]   rise;
    logic [FINE_W-1:0] fine_idx;
    edge_status_e      status;

    dll_rise_finder #(.TAPS(TAPS)) u_finder (
        .snap_i (hit_samples),
        .rise_o (rise)
    );

    dll_rise_encoder #(.TAPS(TAPS)) u_encoder (
        .rise_i   (rise),
        .index_o  (fine_idx),
        .status_o (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_valid <= 1'b0;
            ts_value <= '0;
            ts_err   <= 1'b0;
        end else begin
            ts_valid <= hit_valid;
            if (hit_valid) begin
                ts_value <= {coarse_count, fine_idx};
                ts_err   <= (status != EDGE_OK);
            end
        end
    end

    // R2
    valid_follows_hit_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |=> ts_valid);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |=> !ts_valid);
    // R7
    coarse_captured_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |=> ts_value[TS_W-1 -: COARSE_W] == $past(coarse_count));
    // R5
    err_zero_fine_chk: assert property (@(posedge clk) disable iff (rst)
        ts_err |-> ts_value[FINE_W-1:0] == '0);
    // R8
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |=> $stable(ts_value) && $stable(ts_err));
endmodule

// File: tb/dll_edge_timestamp_test.sv
module dll_edge_timestamp_test;
    localparam int TAPS = 128;
    localparam int CW   = 12;
    localparam int TSW  = CW + 7;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           hit_valid = 1'b0;
    logic [TAPS-1:0] hit_samples = '0;
    logic [CW-1:0]  coarse_count = '0;
    logic           ts_valid;
    logic [TSW-1:0] ts_value;
    logic           ts_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dll_edge_timestamp uut (
        .clk(clk), .rst(rst), .hit_valid(hit_valid),
        .hit_samples(hit_samples), .coarse_count(coarse_count),
        .ts_valid(ts_valid), .ts_value(ts_value), .ts_err(ts_err)
    );

    // {start[6:0], high_len[7:0], coarse[11:0]}
    localparam logic [26:0] VEC [8] = '{
        {7'd0,   8'd64,  12'd0},
        {7'd127, 8'd64,  12'd1},
        {7'd5,   8'd64,  12'd77},
        {7'd64,  8'd64,  12'd2048},
        {7'd100, 8'd1,   12'd4095},
        {7'd3,   8'd127, 12'd300},
        {7'd77,  8'd40,  12'd1234},
        {7'd15,  8'd64,  12'd9}
    };

    function automatic logic [TAPS-1:0] run(input int start, input int len);
        logic [TAPS-1:0] s = '0;
        for (int i = 0; i < len; i++) s[(start + i) % TAPS] = 1'b1;
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hit(input logic [TAPS-1:0] s, input logic [CW-1:0] c);
        @(negedge clk);
        hit_samples  = s;
        coarse_count = c;
        hit_valid    = 1'b1;
        @(negedge clk);
        hit_valid    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with a hit strobe held during reset
        hit_valid = 1'b1;
        hit_samples = run(9, 64);
        repeat (3) @(negedge clk);
        check("R1 valid in reset", ts_valid, 0);
        check("R1 value in reset", ts_value, 0);
        check("R1 err in reset", ts_err, 0);
        hit_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", ts_valid, 0);
        check("R1 value after reset", ts_value, 0);
        check("R1 err after reset", ts_err, 0);

        // R3 R4: table of single-transition snapshots
        for (int v = 0; v < 8; v++) begin
            int st  = int'(VEC[v][26:20]);
            int ln  = int'(VEC[v][19:12]);
            logic [CW-1:0] c = VEC[v][11:0];
            hit(run(st, ln), c);
            check("R2 valid one cycle after hit", ts_valid, 1);
            check("R3 R4 fine position", ts_value[6:0], st);
            check("R7 coarse field", ts_value[18:7], c);
            check("R3 err clear", ts_err, 0);
        end

        @(negedge clk);
        check("R2 valid drops", ts_valid, 0);

        // R5: no transition
        hit('0, 12'd55);
        check("R5 all-zero err", ts_err, 1);
        check("R5 all-zero fine", ts_value[6:0], 0);
        check("R5 all-zero coarse", ts_value[18:7], 55);
        hit('1, 12'd56);
        check("R5 all-one err", ts_err, 1);
        check("R5 all-one fine", ts_value[6:0], 0);

        // R6: bubbles give two transitions
        hit(run(10, 5) | run(50, 20), 12'd600);
        check("R6 bubble err", ts_err, 1);
        check("R6 bubble fine", ts_value[6:0], 0);
        check("R6 bubble coarse", ts_value[18:7], 600);

        // R7: edge at stage 0 / sub 0 at counter rollover
        hit(run(0, 64), 12'd4095);
        coarse_count = 12'd0;
        check("R7 rollover coarse", ts_value[18:7], 4095);
        check("R4 rollover fine", ts_value[6:0], 0);
        check("R4 rollover err", ts_err, 0);

        // R8: outputs hold without a strobe
        hit(run(42, 64), 12'd321);
        for (int i = 0; i < 3; i++) begin
            hit_samples  = run(i * 7, 30);
            coarse_count = 12'(i + 900);
            @(negedge clk);
            check("R8 value held", ts_value, {12'd321, 7'd42});
            check("R8 err held", ts_err, 0);
            check("R2 no valid without hit", ts_valid, 0);
        end

        // R2: back-to-back hits give two valid cycles
        @(negedge clk);
        hit_samples = run(20, 64); coarse_count = 12'd10; hit_valid = 1'b1;
        @(negedge clk);
        check("R2 first of pair", ts_valid, 1);
        check("R3 first of pair fine", ts_value[6:0], 20);
        hit_samples = run(21, 64); coarse_count = 12'd11;
        @(negedge clk);
        hit_valid = 1'b0;
        check("R2 second of pair", ts_valid, 1);
        check("R3 second of pair value", ts_value, {12'd11, 7'd21});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule